// File: doc/BRIEF.md
# Configurable Logic Cell with Pin Stage

This block is one output cell of a programmable logic fabric. A two-bit mode field turns its storage element into a D flip-flop, a toggle flip-flop, a transparent latch, or a plain combinational path. The element is clocked by one of eight candidate sources: two pin-derived global clocks, one device-wide clock, four local control terms, and one product-term clock. A per-cell invert bit makes the chosen source act on its falling edge. Selectable control terms give an asynchronous preset and an asynchronous reset, and a configurable control term can act as a clock enable.

The whole cell runs on one fast system clock, `clk`. A clock source is a level sampled on that clock, and the register acts on the first system-clock edge after the selected source reaches its active level. The data input is the logic-block function output or, for a fast input register, the pad input. A pin stage decodes a 3-bit output-enable selector, flags a weak pull-up, passes the slew bit through, and returns both the cell value and the raw pin value as separate feedback signals.

Top module: `mcell_io`

## Requirements
- R1: While `rst_n` is low, the cell output (`fb_mc`, in a registered mode with no preset or reset active) equals `cfg_init`. After `rst_n` rises, the output keeps that value until a clock event, a preset or a reset occurs.
- R2: `cfg_mode` = 1 selects D mode. On an active edge of the selected clock, the output takes the data input. At any other time it holds, even when the data changes.
- R3: `cfg_mode` = 2 selects T mode. On an active edge, the output inverts when the data input is 1 and the clock enable is true. When the data input is 0, it holds.
- R4: `cfg_mode` = 3 selects latch mode. While the selected clock is at its active level and the enable is true, the output follows the data input. Otherwise it keeps the last value it passed.
- R5: `cfg_mode` = 0 selects combinational mode. The output equals the selected data input at every moment, and clocks, preset and reset have no effect.
- R6: `cfg_clk_sel` chooses the clock: 0 and 1 are `gclk[0]` and `gclk[1]`, 2 is `uclk`, 3 to 6 are `ctl_term[4]` to `ctl_term[7]`, and 7 is `pt_clk`. Edges on sources that are not selected are ignored.
- R7: With `cfg_clk_inv` = 1, the active edge of the selected source is its falling edge, and its rising edge is ignored.
- R8: With `cfg_ce_use` = 1, `ctl_term[4]` low blocks all register and latch updates. With `cfg_ce_use` = 0, updates are always enabled.
- R9: `cfg_pst_sel` and `cfg_rst_sel` use this code: 0 is none, 1 to 6 are `ctl_term[0]` to `ctl_term[5]`, and 7 is `u_pst` or `u_rst` respectively. An active preset forces the output to 1 and an active reset forces it to 0, with no clock edge needed. Reset wins over preset. The forced value remains after the term is released.
- R10: `cfg_din_pin` = 1 takes the data input from `pad_in`. With 0, it comes from `lb_fn`.
- R11: The `cfg_oe_sel` code drives `pad_oe` as follows: 0 gives off, 1 gives `ctl_term[0]`, 2 gives `ctl_term[1]`, 3 gives `ctl_term[2]`, 4 gives `ctl_term[6]`, 5 gives `u_oe`, 6 gives always on, and 7 gives off.
- R12: `pad_wpu` is 1 exactly when `cfg_oe_sel` = 7, and the pad is never enabled while it is 1.
- R13: `fb_pin` always equals `pad_in`, whatever the enable. `pad_do` equals `fb_mc`. `pad_slew` equals `cfg_slew`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-up reset |
| cfg_mode | input | 2 | Element mode: 0 combinational, 1 D, 2 T, 3 latch |
| cfg_clk_sel | input | 3 | Clock source select |
| cfg_clk_inv | input | 1 | Use falling edge / low level of selected source |
| cfg_pst_sel | input | 3 | Preset term select |
| cfg_rst_sel | input | 3 | Reset term select |
| cfg_ce_use | input | 1 | Enable gating by control term 4 |
| cfg_din_pin | input | 1 | Data from pad instead of logic function |
| cfg_oe_sel | input | 3 | Output-enable selector code |
| cfg_init | input | 1 | Power-up value of the element |
| cfg_slew | input | 1 | Slew configuration bit, passed through |
| gclk | input | 2 | Pin-derived global clocks |
| uclk | input | 1 | Device-wide clock |
| pt_clk | input | 1 | Product-term clock |
| ctl_term | input | 8 | Local control terms |
| u_pst | input | 1 | Device-wide preset |
| u_rst | input | 1 | Device-wide reset |
| u_oe | input | 1 | Device-wide output enable |
| lb_fn | input | 1 | Logic-block function output |
| pad_in | input | 1 | Value seen at the pin |
| pad_do | output | 1 | Data to the pin driver |
| pad_oe | output | 1 | Pin driver enable |
| pad_wpu | output | 1 | Weak pull-up active |
| pad_slew | output | 1 | Slew control to the driver |
| fb_mc | output | 1 | Cell value fed back to the interconnect |
| fb_pin | output | 1 | Pin value fed back to the interconnect |

## Verification
Every cycle, the assertions check the things a property can state without modelling edges. Reset beats preset, and preset drives the output high. Combinational mode follows its data source. A blocked clock enable freezes the D output. The output-enable codes for off, pull-up and always-on hold, and the pull-up never appears with the driver enabled. Only the bench scenarios can show the rest. These are edge capture under each clock source and polarity, the toggle sequence, latch transparency and hold, the input-register path, the power-up value, and the enable result of every selector code under two opposite control-term patterns.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [1:0] {
      MC_COMB  = 2'd0,
      MC_DFF   = 2'd1,
      MC_TFF   = 2'd2,
      MC_LATCH = 2'd3
   } mc_mode_e;

   localparam int MC_SEL_W = 3;

   localparam logic [MC_SEL_W-1:0] OE_OFF  = 3'd0;
   localparam logic [MC_SEL_W-1:0] OE_CTA  = 3'd1;
   localparam logic [MC_SEL_W-1:0] OE_CTB  = 3'd2;
   localparam logic [MC_SEL_W-1:0] OE_CTC  = 3'd3;
   localparam logic [MC_SEL_W-1:0] OE_CTD  = 3'd4;
   localparam logic [MC_SEL_W-1:0] OE_UNI  = 3'd5;
   localparam logic [MC_SEL_W-1:0] OE_ON   = 3'd6;
   localparam logic [MC_SEL_W-1:0] OE_PULL = 3'd7;

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
   parameter int NUM_GCLK = 2,
   parameter int NUM_LCLK = 4,
   parameter int SEL_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic                uclk,
   input  logic [NUM_LCLK-1:0] lclk,
   input  logic                pt_clk,
   input  logic [SEL_W-1:0]    sel,
   input  logic                inv,
   output logic                gate_lvl,
   output logic                edge_hit
);
   localparam int NUM_SRC = NUM_GCLK + NUM_LCLK + 2;

   generate
      if (NUM_SRC != (1 << SEL_W)) begin : g_bad_src
         $error("clock source count must fill the select code");
      end
   endgenerate

   logic [NUM_SRC-1:0] src;
   logic               prev_lvl;

   assign src      = {pt_clk, lclk, uclk, gclk};
   assign gate_lvl = src[sel] ^ inv;
   assign edge_hit = gate_lvl & ~prev_lvl;

   // Start high so that a source already active at reset release is no edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= 1'b1;
      else        prev_lvl <= gate_lvl;
   end
endmodule

// File: rtl/mc_ctrl_sel.sv
module mc_ctrl_sel #(
   parameter int NUM_FCT = 6,
   parameter int SEL_W   = 3
) (
   input  logic [NUM_FCT-1:0] fct,
   input  logic [SEL_W-1:0]   pst_sel,
   input  logic [SEL_W-1:0]   rst_sel,
   input  logic               u_pst,
   input  logic               u_rst,
   input  logic               ce_use,
   input  logic               ce_term,
   output logic               pst_act,
   output logic               rst_act,
   output logic               ce
);
   localparam logic [SEL_W-1:0] SEL_UNI = {SEL_W{1'b1}};

   generate
      if (NUM_FCT != (1 << SEL_W) - 2) begin : g_bad_fct
         $error("force term count must match the select code");
      end
   endgenerate

   function automatic logic pick(input logic [SEL_W-1:0] code,
                                 input logic [NUM_FCT-1:0] terms,
                                 input logic uni);
      logic [SEL_W-1:0] idx;
      idx = code - 1'b1;
      if (code == '0)           return 1'b0;
      else if (code == SEL_UNI) return uni;
      else                      return terms[idx];
   endfunction

   assign pst_act = pick(pst_sel, fct, u_pst);
   assign rst_act = pick(rst_sel, fct, u_rst);
   assign ce      = ~ce_use | ce_term;
endmodule

// File: rtl/mc_store.sv
module mc_store
   import mc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  mc_mode_e mode,
   input  logic     init_val,
   input  logic     d,
   input  logic     edge_hit,
   input  logic     gate_lvl,
   input  logic     ce,
   input  logic     pst_act,
   input  logic     rst_act,
   output logic     q
);
   logic q_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_reg <= init_val;
      end else if (mode == MC_COMB) begin
         q_reg <= d;
      end else if (rst_act) begin
         q_reg <= 1'b0;
      end else if (pst_act) begin
         q_reg <= 1'b1;
      end else begin
         unique case (mode)
            MC_DFF:   if (edge_hit && ce) q_reg <= d;
            MC_TFF:   if (edge_hit && ce && d) q_reg <= ~q_reg;
            MC_LATCH: if (gate_lvl && ce) q_reg <= d;
            default:  q_reg <= q_reg;
         endcase
      end
   end

   // Forcing terms act on the output at once, ahead of any clock.
   always_comb begin
      if (mode == MC_COMB)                        q = d;
      else if (rst_act)                           q = 1'b0;
      else if (pst_act)                           q = 1'b1;
      else if (mode == MC_LATCH && gate_lvl && ce) q = d;
      else                                        q = q_reg;
   end
endmodule

// File: rtl/mc_io_cell.sv
module mc_io_cell
   import mc_pkg::*;
(
   input  logic [MC_SEL_W-1:0] oe_sel,
   input  logic [3:0]          oe_ct,
   input  logic                u_oe,
   input  logic                q,
   input  logic                pad_in,
   input  logic                slew,
   output logic                pad_do,
   output logic                pad_oe,
   output logic                pad_wpu,
   output logic                pad_slew,
   output logic                fb_pin
);
   always_comb begin
      unique case (oe_sel)
         OE_CTA:  pad_oe = oe_ct[0];
         OE_CTB:  pad_oe = oe_ct[1];
         OE_CTC:  pad_oe = oe_ct[2];
         OE_CTD:  pad_oe = oe_ct[3];
         OE_UNI:  pad_oe = u_oe;
         OE_ON:   pad_oe = 1'b1;
         default: pad_oe = 1'b0;
      endcase
   end

   assign pad_wpu  = (oe_sel == OE_PULL);
   assign pad_do   = q;
   assign pad_slew = slew;
   assign fb_pin   = pad_in;
endmodule

// File: rtl/mcell_io.sv
module mcell_io
   import mc_pkg::*;
#(
   parameter int NUM_CT    = 8,
   parameter int NUM_GCLK  = 2,
   parameter int NUM_LCLK  = 4,
   parameter int LCLK_BASE = 4,
   parameter int NUM_FCT   = 6,
   parameter int CE_IDX    = 4,
   parameter int OE_IDX_A  = 0,
   parameter int OE_IDX_B  = 1,
   parameter int OE_IDX_C  = 2,
   parameter int OE_IDX_D  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_mode,
   input  logic [2:0]          cfg_clk_sel,
   input  logic                cfg_clk_inv,
   input  logic [2:0]          cfg_pst_sel,
   input  logic [2:0]          cfg_rst_sel,
   input  logic                cfg_ce_use,
   input  logic                cfg_din_pin,
   input  logic [2:0]          cfg_oe_sel,
   input  logic                cfg_init,
   input  logic                cfg_slew,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic                uclk,
   input  logic                pt_clk,
   input  logic [NUM_CT-1:0]   ctl_term,
   input  logic                u_pst,
   input  logic                u_rst,
   input  logic                u_oe,
   input  logic                lb_fn,
   input  logic                pad_in,
   output logic                pad_do,
   output logic                pad_oe,
   output logic                pad_wpu,
   output logic                pad_slew,
   output logic                fb_mc,
   output logic                fb_pin
);
   localparam int LCLK_TOP = LCLK_BASE + NUM_LCLK;

   generate
      if (LCLK_TOP > NUM_CT || NUM_FCT > NUM_CT || CE_IDX >= NUM_CT) begin : g_bad_ct
         $error("control term indices exceed the term count");
      end
      if (OE_IDX_A >= NUM_CT || OE_IDX_B >= NUM_CT ||
          OE_IDX_C >= NUM_CT || OE_IDX_D >= NUM_CT) begin : g_bad_oe
         $error("enable term index exceeds the term count");
      end
   endgenerate

   logic gate_lvl, edge_hit, pst_act, rst_act, ce, d_src, q;
   logic [3:0] oe_ct;

   assign d_src = cfg_din_pin ? pad_in : lb_fn;
   assign oe_ct = {ctl_term[OE_IDX_D], ctl_term[OE_IDX_C],
                   ctl_term[OE_IDX_B], ctl_term[OE_IDX_A]};

   mc_clk_sel #(
      .NUM_GCLK (NUM_GCLK),
      .NUM_LCLK (NUM_LCLK),
      .SEL_W    (MC_SEL_W)
   ) clk_sel_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .gclk     (gclk),
      .uclk     (uclk),
      .lclk     (ctl_term[LCLK_BASE +: NUM_LCLK]),
      .pt_clk   (pt_clk),
      .sel      (cfg_clk_sel),
      .inv      (cfg_clk_inv),
      .gate_lvl (gate_lvl),
      .edge_hit (edge_hit)
   );

   mc_ctrl_sel #(
      .NUM_FCT (NUM_FCT),
      .SEL_W   (MC_SEL_W)
   ) ctrl_sel_i (
      .fct     (ctl_term[NUM_FCT-1:0]),
      .pst_sel (cfg_pst_sel),
      .rst_sel (cfg_rst_sel),
      .u_pst   (u_pst),
      .u_rst   (u_rst),
      .ce_use  (cfg_ce_use),
      .ce_term (ctl_term[CE_IDX]),
      .pst_act (pst_act),
      .rst_act (rst_act),
      .ce      (ce)
   );

   mc_store store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mc_mode_e'(cfg_mode)),
      .init_val (cfg_init),
      .d        (d_src),
      .edge_hit (edge_hit),
      .gate_lvl (gate_lvl),
      .ce       (ce),
      .pst_act  (pst_act),
      .rst_act  (rst_act),
      .q        (q)
   );

   mc_io_cell io_i (
      .oe_sel   (cfg_oe_sel),
      .oe_ct    (oe_ct),
      .u_oe     (u_oe),
      .q        (q),
      .pad_in   (pad_in),
      .slew     (cfg_slew),
      .pad_do   (pad_do),
      .pad_oe   (pad_oe),
      .pad_wpu  (pad_wpu),
      .pad_slew (pad_slew),
      .fb_pin   (fb_pin)
   );

   assign fb_mc = q;
endmodule

// File: rtl/mcell_io_chk.sv
module mcell_io_chk #(
   parameter int CE_IDX = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic [2:0] cfg_pst_sel,
   input logic [2:0] cfg_rst_sel,
   input logic       cfg_ce_use,
   input logic       cfg_din_pin,
   input logic [2:0] cfg_oe_sel,
   input logic [7:0] ctl_term,
   input logic       u_pst,
   input logic       u_rst,
   input logic       lb_fn,
   input logic       pad_in,
   input logic       fb_mc,
   input logic       pad_oe,
   input logic       pad_wpu
);
   logic pst_hit, rst_hit, ce_off, d_now;
   logic [2:0] pst_i, rst_i;

   assign pst_i   = cfg_pst_sel - 3'd1;
   assign rst_i   = cfg_rst_sel - 3'd1;
   assign pst_hit = (cfg_pst_sel == 3'd7) ? u_pst :
                    (cfg_pst_sel != 3'd0) && ctl_term[pst_i];
   assign rst_hit = (cfg_rst_sel == 3'd7) ? u_rst :
                    (cfg_rst_sel != 3'd0) && ctl_term[rst_i];
   assign ce_off  = cfg_ce_use && !ctl_term[CE_IDX];
   assign d_now   = cfg_din_pin ? pad_in : lb_fn;

   AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'd0 && rst_hit) |-> !fb_mc);  // R9

   AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'd0 && pst_hit && !rst_hit) |-> fb_mc);  // R9

   AST_COMB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd0) |-> (fb_mc == d_now));  // R5

   AST_CE_FREEZES_D: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd1 && ce_off && !pst_hit && !rst_hit)
      |=> (cfg_mode != 2'd1 || pst_hit || rst_hit || $stable(fb_mc)));  // R8

   AST_OE_OFF_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_oe_sel == 3'd0 || cfg_oe_sel == 3'd7) |-> !pad_oe);  // R11

   AST_OE_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_oe_sel == 3'd6) |-> pad_oe);  // R11

   AST_PULLUP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      pad_wpu |-> (!pad_oe && cfg_oe_sel == 3'd7));  // R12
endmodule

bind mcell_io mcell_io_chk #(.CE_IDX(CE_IDX)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_mode    (cfg_mode),
   .cfg_pst_sel (cfg_pst_sel),
   .cfg_rst_sel (cfg_rst_sel),
   .cfg_ce_use  (cfg_ce_use),
   .cfg_din_pin (cfg_din_pin),
   .cfg_oe_sel  (cfg_oe_sel),
   .ctl_term    (ctl_term),
   .u_pst       (u_pst),
   .u_rst       (u_rst),
   .lb_fn       (lb_fn),
   .pad_in      (pad_in),
   .fb_mc       (fb_mc),
   .pad_oe      (pad_oe),
   .pad_wpu     (pad_wpu)
);

// File: tb/mcell_io_tb_top.sv
module mcell_io_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 20000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] cfg_mode;
   logic [2:0] cfg_clk_sel;
   logic       cfg_clk_inv;
   logic [2:0] cfg_pst_sel, cfg_rst_sel;
   logic       cfg_ce_use, cfg_din_pin;
   logic [2:0] cfg_oe_sel;
   logic       cfg_init, cfg_slew;
   logic [1:0] gclk;
   logic       uclk, pt_clk;
   logic [7:0] ctl_term;
   logic       u_pst, u_rst, u_oe, lb_fn, pad_in;
   logic       pad_do, pad_oe, pad_wpu, pad_slew, fb_mc, fb_pin;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int    kq[$];
   logic  vq[$];
   string tq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mcell_io dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
      .cfg_clk_inv(cfg_clk_inv), .cfg_pst_sel(cfg_pst_sel), .cfg_rst_sel(cfg_rst_sel),
      .cfg_ce_use(cfg_ce_use), .cfg_din_pin(cfg_din_pin), .cfg_oe_sel(cfg_oe_sel),
      .cfg_init(cfg_init), .cfg_slew(cfg_slew), .gclk(gclk), .uclk(uclk),
      .pt_clk(pt_clk), .ctl_term(ctl_term), .u_pst(u_pst), .u_rst(u_rst),
      .u_oe(u_oe), .lb_fn(lb_fn), .pad_in(pad_in), .pad_do(pad_do),
      .pad_oe(pad_oe), .pad_wpu(pad_wpu), .pad_slew(pad_slew),
      .fb_mc(fb_mc), .fb_pin(fb_pin)
   );

   function automatic logic observe(input int kind);
      case (kind)
         0:       return fb_mc;
         1:       return pad_oe;
         2:       return pad_wpu;
         3:       return fb_pin;
         4:       return pad_do;
         default: return pad_slew;
      endcase
   endfunction

   // Monitor: compares queued expectations against the outputs at the falling edge.
   always @(negedge clk) begin
      while (kq.size() > 0) begin
         int    k;
         logic  v, a;
         string t;
         k = kq.pop_front();
         v = vq.pop_front();
         t = tq.pop_front();
         a = observe(k);
         checks++;
         if (a !== v) begin
            failures++;
            $display("FAIL %s (out %0d): actual=%0b expected=%0b", t, k, a, v);
         end
      end
   end

   task automatic expect_out(input int kind, input logic val, input string tag);
      kq.push_back(kind);
      vq.push_back(val);
      tq.push_back(tag);
   endtask

   task automatic check_now(input int kind, input logic val, input string tag);
      logic a;
      a = observe(kind);
      checks++;
      if (a !== val) begin
         failures++;
         $display("FAIL %s (out %0d): actual=%0b expected=%0b", tag, kind, a, val);
      end
   endtask

   task automatic bc();
      @(negedge clk);
      #1;
   endtask

   task automatic ec();
      @(posedge clk);
      #1;
   endtask

   task automatic set_src(input int idx, input logic v);
      case (idx)
         0:          gclk[0] = v;
         1:          gclk[1] = v;
         2:          uclk = v;
         3, 4, 5, 6: ctl_term[idx+1] = v;
         default:    pt_clk = v;
      endcase
   endtask

   task automatic make_edge(input int idx);
      bc(); set_src(idx, cfg_clk_inv);  ec();
      bc(); set_src(idx, ~cfg_clk_inv); ec();
   endtask

   function automatic logic oe_model(input int code);
      case (code)
         1:       return ctl_term[0];
         2:       return ctl_term[1];
         3:       return ctl_term[2];
         4:       return ctl_term[6];
         5:       return u_oe;
         6:       return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic oe_sweep(input string tag);
      for (int c = 0; c < 8; c++) begin
         bc(); cfg_oe_sel = 3'(c); ec();
         expect_out(1, oe_model(c), {tag, " R11 enable code"});
         expect_out(2, c == 7, "R12 pull-up flag");
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG_CYCLES);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cfg_mode = 2'd1; cfg_clk_sel = 3'd0; cfg_clk_inv = 0;
      cfg_pst_sel = 0; cfg_rst_sel = 0; cfg_ce_use = 0; cfg_din_pin = 0;
      cfg_oe_sel = 3'd6; cfg_init = 1; cfg_slew = 0; gclk = 0; uclk = 0;
      pt_clk = 0; ctl_term = 0; u_pst = 0; u_rst = 0; u_oe = 0;
      lb_fn = 0; pad_in = 0;

      // R1 power-up value
      ec(); expect_out(0, 1'b1, "R1 init set");
      bc(); cfg_init = 0; ec(); expect_out(0, 1'b0, "R1 init clear");
      bc(); rst_n = 1; ec(); expect_out(0, 1'b0, "R1 kept after release");

      // R2 D capture and hold
      bc(); lb_fn = 1; ec();
      make_edge(0); expect_out(0, 1'b1, "R2 capture 1");
      bc(); lb_fn = 0; ec(); expect_out(0, 1'b1, "R2 hold without edge");
      make_edge(0); expect_out(0, 1'b0, "R2 capture 0");

      // R6 clock selection
      bc(); cfg_clk_sel = 3'd7; lb_fn = 1; ec();
      make_edge(0); expect_out(0, 1'b0, "R6 unselected source ignored");
      make_edge(7); expect_out(0, 1'b1, "R6 product-term clock");
      bc(); cfg_clk_sel = 3'd3; lb_fn = 0; ec();
      make_edge(3); expect_out(0, 1'b0, "R6 local clock term 4");
      bc(); cfg_clk_sel = 3'd2; lb_fn = 1; ec();
      make_edge(2); expect_out(0, 1'b1, "R6 device-wide clock");

      // R7 inverted clock
      bc(); cfg_clk_sel = 3'd7; cfg_clk_inv = 1; lb_fn = 0; ec();
      make_edge(7); expect_out(0, 1'b0, "R7 falling edge capture");
      bc(); lb_fn = 1; pt_clk = 1; ec(); expect_out(0, 1'b0, "R7 rising edge ignored");
      bc(); gclk[0] = 0; cfg_clk_sel = 3'd0; cfg_clk_inv = 0; ec();
      expect_out(0, 1'b0, "R7 no edge on reselect");

      // R8 clock enable
      bc(); cfg_ce_use = 1; ctl_term[4] = 0; lb_fn = 1; ec();
      make_edge(0); expect_out(0, 1'b0, "R8 enable low blocks");
      bc(); ctl_term[4] = 1; ec();
      make_edge(0); expect_out(0, 1'b1, "R8 enable high passes");
      bc(); cfg_ce_use = 0; ctl_term[4] = 0; ec();

      // R3 toggle mode
      bc(); cfg_mode = 2'd2; lb_fn = 1; ec();
      make_edge(0); expect_out(0, 1'b0, "R3 toggle to 0");
      make_edge(0); expect_out(0, 1'b1, "R3 toggle to 1");
      bc(); lb_fn = 0; ec();
      make_edge(0); expect_out(0, 1'b1, "R3 T=0 holds");
      bc(); lb_fn = 1; cfg_ce_use = 1; ec();
      make_edge(0); expect_out(0, 1'b1, "R3 enable low holds");
      bc(); cfg_ce_use = 0; ec();

      // R4 latch mode (gclk[0] is high, gate open)
      bc(); cfg_mode = 2'd3; lb_fn = 0; ec(); expect_out(0, 1'b0, "R4 transparent 0");
      bc(); lb_fn = 1; ec(); expect_out(0, 1'b1, "R4 transparent 1");
      bc(); gclk[0] = 0; ec(); expect_out(0, 1'b1, "R4 gate closed");
      bc(); lb_fn = 0; ec(); expect_out(0, 1'b1, "R4 hold while closed");

      // R5 combinational
      bc(); cfg_mode = 2'd0; ec(); expect_out(0, 1'b0, "R5 comb 0");
      bc(); lb_fn = 1; #1 check_now(0, 1'b1, "R5 comb immediate");
      bc(); u_rst = 1; cfg_rst_sel = 3'd7; ec(); expect_out(0, 1'b1, "R5 reset ignored");
      bc(); u_rst = 0; cfg_rst_sel = 0; ec();

      // R10 fast input register
      bc(); cfg_mode = 2'd1; cfg_din_pin = 1; pad_in = 1; lb_fn = 0; ec();
      make_edge(0); expect_out(0, 1'b1, "R10 pad data captured");
      bc(); pad_in = 0; lb_fn = 1; ec();
      make_edge(0); expect_out(0, 1'b0, "R10 logic data ignored");
      bc(); cfg_din_pin = 0; lb_fn = 0; ec();

      // R9 preset and reset
      bc(); cfg_pst_sel = 3'd1; ctl_term[0] = 1; #1 check_now(0, 1'b1, "R9 preset at once");
      bc(); ctl_term[0] = 0; ec(); expect_out(0, 1'b1, "R9 preset retained");
      bc(); cfg_rst_sel = 3'd2; ctl_term[1] = 1; #1 check_now(0, 1'b0, "R9 reset at once");
      bc(); ctl_term[0] = 1; ec(); expect_out(0, 1'b0, "R9 reset wins");
      bc(); ctl_term[1:0] = 2'b00; ec(); expect_out(0, 1'b0, "R9 reset retained");
      bc(); cfg_pst_sel = 3'd7; cfg_rst_sel = 3'd7; u_pst = 1; ec();
      expect_out(0, 1'b1, "R9 universal preset");
      bc(); u_rst = 1; ec(); expect_out(0, 1'b0, "R9 universal reset wins");
      bc(); u_pst = 0; u_rst = 0; cfg_pst_sel = 0; cfg_rst_sel = 0; ec();
      expect_out(0, 1'b0, "R9 released");

      // R11 / R12 enable decode under two term patterns
      bc(); ctl_term[0] = 1; ctl_term[1] = 0; ctl_term[2] = 1; ctl_term[6] = 0; u_oe = 1; ec();
      oe_sweep("pattern A");
      bc(); ctl_term[0] = 0; ctl_term[1] = 1; ctl_term[2] = 0; ctl_term[6] = 1; u_oe = 0; ec();
      oe_sweep("pattern B");

      // R13 feedback and pass-through (cfg_oe_sel is 7: pad undriven)
      bc(); pad_in = 1; cfg_slew = 1; ec();
      expect_out(3, 1'b1, "R13 pin feedback while undriven");
      expect_out(5, 1'b1, "R13 slew pass");
      expect_out(4, 1'b0, "R13 pad data equals cell");
      bc(); ctl_term = 0; cfg_pst_sel = 3'd1; ctl_term[0] = 1; pad_in = 0; ec();
      expect_out(4, 1'b1, "R13 pad data after preset");
      expect_out(3, 1'b0, "R13 pin feedback low");

      bc(); bc();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule